// File: doc/BRIEF.md
# Single-Bus Processor Core with Hardwired Step Sequencer

This block is a compact processor core in which every internal transfer travels over one shared data bus. The core holds a small file of general registers, a program counter, an instruction register, two hidden working registers (an ALU operand latch and an ALU result latch), and an address/data register pair that faces memory. Every register has its own strobe to drive the bus and its own strobe to capture the bus value at the clock edge. A step counter, together with logic decoded from the opcode, raises these strobes one step at a time.

The core runs four operations: a three-operand register add, a word load through an address register, a word store through an address register, and an unconditional branch relative to the address of the following instruction. Memory is reached through a request/complete handshake. Each step that waits for memory holds the step counter until the completion input is seen. The ALU has one adder. Its first operand is either the operand latch or the constant 4, its second operand is the bus, and its sum goes to the result latch. The program counter advances through this same adder during fetch.

Instruction word layout: opcode in bits [31:28], destination register in [26:24], first source (the address register for load and store) in [22:20], second source (the data register for store) in [18:16], and a signed 16-bit byte offset in [15:0]. Opcodes: 1 = add, 2 = load, 3 = store, 4 = branch. Every other value does nothing.

Top module: `sb_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mem_req` is low, the step counter is at step 1 and the program counter is 0. The first request after reset is a read of address 0.
- R2: Each instruction starts with a read (`mem_we`=0) at the program counter. Unless the instruction was a branch, the next fetch address is 4 higher.
- R3: Opcode 1 writes the sum, modulo 2^32, of the registers named in [22:20] and [18:16] into the register named in [26:24].
- R4: Opcode 2 issues a read at the value of register [22:20] and writes the returned word into register [26:24].
- R5: Opcode 3 issues a write (`mem_we`=1) at the address held in register [22:20], with `mem_wdata` equal to register [18:16].
- R6: Opcode 4 sets the next fetch address to the branch's own address + 4 + the sign-extended field [15:0].
- R7: During a wait-for-memory step with `mem_done` low, the step counter holds and no register drive or load strobe is active. Results and step spacing do not depend on memory latency.
- R8: At most one source drives the internal bus in any cycle.
- R9: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until the cycle in which `mem_done` is sampled high. It drops on the following edge.
- R10: Any opcode other than 1..4 changes no register and no memory location. The next fetch is at the following word.
- R11: An instruction's last step returns the counter to step 1. Counted in clock edges from the edge that takes a fetch completion to the edge that raises the next request: add 6, branch 5, no-op 4, fetch to load request 3, load completion to next fetch 3, fetch to store request 4, store completion to next fetch 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access request, held until completion |
| mem_we | output | 1 | 1 for write, 0 for read; valid while `mem_req` is high |
| mem_addr | output | DATA_W | Byte address taken from the address register |
| mem_wdata | output | DATA_W | Store data taken from the data register |
| mem_rdata | input | DATA_W | Read data, sampled when `mem_done` is high on a read |
| mem_done | input | 1 | Memory function complete, high for one cycle |

## Verification
The case that is hardest to reach from the ports is a stalled wait step: a request is held for many cycles and completion then arrives during the fetch wait, the load wait or the store wait, and the counter must resume at the correct point. The bench memory model draws a random latency of 0 to 3 cycles for each access and makes an occasional 12-cycle stall. It checks that the address stays fixed while it waits, and it measures the spacing in edges from each completion to the next request. A random instruction stream, with directed sequences at its start (a backward detour branch, a zero-offset branch, unknown opcodes placed before stores), makes every kind of wait occur many times.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // instruction field positions (decoded by the sequencer and register file)
  localparam int OP_LO  = 28;
  localparam int DST_LO = 24;
  localparam int SRA_LO = 20;
  localparam int SRB_LO = 16;
  localparam int OFF_W  = 16;

  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_LD  = 4'h2;
  localparam logic [3:0] OP_ST  = 4'h3;
  localparam logic [3:0] OP_BR  = 4'h4;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mdr_out;
    logic mdr_in;
    logic ir_in;
    logic off_out;
    logic y_in;
    logic z_out;
    logic z_in;
    logic use_y;
    logic rf_out;
    logic rf_src_b;
    logic rf_in;
    logic rd_req;
    logic wr_req;
    logic wmfc;
    logic fin;
  } strobe_t;
endpackage

// File: rtl/sb_step_ctr.sv
module sb_step_ctr #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              fin,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       step <= FIRST;
    else if (hold) step <= step;
    else if (fin)  step <= FIRST;
    else           step <= step + 1'b1;
  end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  logic [3:0]        opcode,
  input  logic              mem_done,
  output strobe_t           s,
  output logic              waiting
);
  localparam int NSTEP = 1 << STEP_W;

  logic [NSTEP-1:0] t;
  logic is_add, is_ld, is_st, is_br, is_nop;
  strobe_t raw;

  always_comb begin
    t = '0;
    t[step] = 1'b1;
  end

  assign is_add = (opcode == OP_ADD);
  assign is_ld  = (opcode == OP_LD);
  assign is_st  = (opcode == OP_ST);
  assign is_br  = (opcode == OP_BR);
  assign is_nop = ~(is_add | is_ld | is_st | is_br);

  // sum-of-products strobe equations
  always_comb begin
    raw          = '0;
    raw.pc_out   = t[1];
    raw.mar_in   = t[1] | (t[4] & (is_ld | is_st));
    raw.rd_req   = t[1] | (t[4] & is_ld);
    raw.z_in     = t[1] | (t[5] & is_add) | (t[4] & is_br);
    raw.use_y    = (t[5] & is_add) | (t[4] & is_br);
    raw.z_out    = t[2] | (t[6] & is_add) | (t[5] & is_br);
    raw.pc_in    = t[2] | (t[5] & is_br);
    raw.y_in     = t[2] | (t[4] & is_add);
    raw.mdr_out  = t[3] | (t[6] & is_ld);
    raw.ir_in    = t[3];
    raw.off_out  = t[4] & is_br;
    raw.rf_out   = (t[4] & (is_add | is_ld | is_st)) | (t[5] & (is_add | is_st));
    raw.rf_src_b = t[5];
    raw.rf_in    = t[6] & (is_add | is_ld);
    raw.mdr_in   = t[5] & is_st;
    raw.wr_req   = t[5] & is_st;
    raw.wmfc     = t[2] | (t[5] & is_ld) | (t[6] & is_st);
    raw.fin      = (t[6] & (is_add | is_ld | is_st)) | (t[5] & is_br) | (t[4] & is_nop);
  end

  assign waiting = raw.wmfc & ~mem_done;

  always_comb begin
    if (waiting) begin
      s      = '0;
      s.wmfc = 1'b1;
    end else begin
      s = raw;
    end
  end
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/sb_alu.sv
module sb_alu #(
  parameter int DATA_W = 32,
  parameter int INC    = 4
) (
  input  logic              use_y,
  input  logic [DATA_W-1:0] y,
  input  logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] sum
);
  localparam logic [DATA_W-1:0] KONST = DATA_W'(INC);

  logic [DATA_W-1:0] opa;

  assign opa = use_y ? y : KONST;
  assign sum = opa + bus;
endmodule

// File: rtl/sb_core.sv
module sb_core
  import sb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_done
);
  localparam int REG_AW = $clog2(NREG);
  localparam int STEP_W = 3;
  localparam int NDRV   = 5;
  localparam int NLD    = 7;

  logic [DATA_W-1:0] pc_q, ir_q, y_q, z_q, mar_q, mdr_q;
  logic [DATA_W-1:0] bus, alu_sum, rf_rdata, off_ext;
  logic [STEP_W-1:0] step;
  logic [REG_AW-1:0] dst_sel, sra_sel, srb_sel, rd_sel;
  logic [NDRV-1:0]   drv_vec;
  logic [NLD-1:0]    ld_vec;
  logic [DATA_W-1:0] drv_val [NDRV];
  logic              waiting, end_s;
  strobe_t           s;

  assign dst_sel = ir_q[DST_LO +: REG_AW];
  assign sra_sel = ir_q[SRA_LO +: REG_AW];
  assign srb_sel = ir_q[SRB_LO +: REG_AW];
  assign rd_sel  = s.rf_src_b ? srb_sel : sra_sel;
  assign off_ext = {{(DATA_W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

  sb_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .step     (step),
    .opcode   (ir_q[OP_LO +: 4]),
    .mem_done (mem_done),
    .s        (s),
    .waiting  (waiting)
  );

  sb_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk  (clk),
    .rst  (rst),
    .hold (waiting),
    .fin  (s.fin),
    .step (step)
  );

  sb_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (s.rf_in),
    .waddr (dst_sel),
    .wdata (bus),
    .raddr (rd_sel),
    .rdata (rf_rdata)
  );

  sb_alu #(.DATA_W(DATA_W), .INC(4)) u_alu (
    .use_y (s.use_y),
    .y     (y_q),
    .bus   (bus),
    .sum   (alu_sum)
  );

  // bus sources: AND-OR mux, one enable per source
  assign drv_vec    = {s.pc_out, s.mdr_out, s.off_out, s.z_out, s.rf_out};
  assign drv_val[4] = pc_q;
  assign drv_val[3] = mdr_q;
  assign drv_val[2] = off_ext;
  assign drv_val[1] = z_q;
  assign drv_val[0] = rf_rdata;

  logic [DATA_W-1:0] bus_term [NDRV];
  for (genvar g = 0; g < NDRV; g++) begin : g_bus
    assign bus_term[g] = {DATA_W{drv_vec[g]}} & drv_val[g];
  end

  always_comb begin
    bus = '0;
    for (int k = 0; k < NDRV; k++) bus = bus | bus_term[k];
  end

  assign ld_vec = {s.pc_in, s.mar_in, s.mdr_in, s.ir_in, s.y_in, s.z_in, s.rf_in};
  assign end_s  = s.fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      y_q   <= '0;
      z_q   <= '0;
      mar_q <= '0;
    end else begin
      if (s.pc_in)  pc_q  <= bus;
      if (s.ir_in)  ir_q  <= bus;
      if (s.y_in)   y_q   <= bus;
      if (s.z_in)   z_q   <= alu_sum;
      if (s.mar_in) mar_q <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 mdr_q <= '0;
    else if (s.mdr_in)                       mdr_q <= bus;
    else if (mem_req && mem_done && !mem_we) mdr_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end else if (s.rd_req || s.wr_req) begin
      mem_req <= 1'b1;
      mem_we  <= s.wr_req;
    end else if (mem_done) begin
      mem_req <= 1'b0;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
endmodule

// File: rtl/sb_core_checks.sv
module sb_core_checks #(
  parameter int DATA_W = 32,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic [4:0]        drv_vec,
  input logic [6:0]        ld_vec,
  input logic              waiting,
  input logic              mem_req,
  input logic              mem_done,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] pc_q,
  input logic              end_s
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0 && step == STEP_W'(1) && !mem_req));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    waiting |=> step == $past(step));

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    waiting |-> (ld_vec == '0 && drv_vec == '0));

  assert_single_driver_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_vec));

  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)));

  assert_wait_has_req_R9: assert property (@(posedge clk) disable iff (rst)
    waiting |-> mem_req);

  assert_end_restart_R11: assert property (@(posedge clk) disable iff (rst)
    end_s |=> step == STEP_W'(1));
endmodule

bind sb_core sb_core_checks #(.DATA_W(DATA_W), .STEP_W(STEP_W)) chk (.*);

// File: tb/sb_core_test.sv
module sb_core_test;
  localparam int W    = 32;
  localparam int MEMW = 256;
  localparam int MAXA = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_req, mem_we, mem_done;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  sb_core #(.DATA_W(W), .NREG(8)) uut (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_done  (mem_done)
  );

  logic [W-1:0] mem [MEMW];
  logic [W-1:0] ex_addr [MAXA];
  logic [W-1:0] ex_data [MAXA];
  logic         ex_we   [MAXA];
  int           ex_gap  [MAXA];
  string        ex_tag  [MAXA];
  int n_exp = 0, n_seen = 0, n_chk = 0, n_bad = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int d, input int a,
                                      input int b, input int off);
    logic [31:0] o = off;
    logic [3:0]  p = op[3:0];
    return {p, 1'b0, d[2:0], 1'b0, a[2:0], 1'b0, b[2:0], o[15:0]};
  endfunction

  task automatic push(input logic we, input logic [W-1:0] a, input logic [W-1:0] d,
                      input int gap, input string tag);
    ex_we[n_exp] = we; ex_addr[n_exp] = a; ex_data[n_exp] = d;
    ex_gap[n_exp] = gap; ex_tag[n_exp] = tag;
    n_exp++;
  endtask

  // memory responder: random latency, occasional long stall
  initial begin
    int wc, lat, plat, t_done;
    logic [W-1:0] a0;
    bit busy, hold_ok;
    wc = 0; lat = 0; plat = 0; t_done = 0; a0 = '0; busy = 0; hold_ok = 1;
    mem_done = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_done = 1'b0;
      if (!rst && mem_req) begin
        if (!busy) begin
          busy = 1; wc = 0; a0 = mem_addr; hold_ok = 1;
          if (n_seen > 0 && n_seen < n_exp)
            chk(cyc - t_done == ex_gap[n_seen], (plat > 0) ? "R7" : "R11",
                "edges completion->request", W'(cyc - t_done), W'(ex_gap[n_seen]));
          lat = (($urandom % 16) == 0) ? 12 : int'($urandom % 4);
        end else if (mem_addr !== a0) begin
          hold_ok = 0;
        end
        if (wc == lat) begin
          mem_done = 1'b1; busy = 0; t_done = cyc; plat = lat;
          if (n_seen < n_exp) begin
            chk(mem_addr == ex_addr[n_seen], ex_tag[n_seen], "access address",
                mem_addr, ex_addr[n_seen]);
            chk(mem_we == ex_we[n_seen], ex_tag[n_seen], "access direction",
                W'(mem_we), W'(ex_we[n_seen]));
            if (ex_we[n_seen])
              chk(mem_wdata == ex_data[n_seen], "R3/R5/R8", "store data",
                  mem_wdata, ex_data[n_seen]);
            if (lat > 0)
              chk(hold_ok, "R9", "address held while waiting", W'(hold_ok), W'(1));
          end
          mem_rdata = mem[mem_addr[9:2]];
          n_seen++;
        end else begin
          wc++;
        end
      end
    end
  end

  initial begin
    int p, pdet, k, r;
    logic [W-1:0] rg [8];
    logic [W-1:0] pc, w, off;
    int gap;
    string tag;
    bit halted;

    void'($urandom(32'd2718));
    for (int i = 0; i < MEMW; i++) mem[i] = $urandom;

    // directed opening sequence
    p = 0;
    mem[p] = enc(2, 1, 0, 0, int'($urandom % 65536)); p++;  // ld r1,(r0)
    mem[p] = enc(2, 2, 1, 0, 0);            p++;            // ld r2,(r1)
    mem[p] = enc(1, 3, 1, 2, 0);            p++;            // add r3=r1+r2
    mem[p] = enc(3, 0, 2, 3, 0);            p++;            // st r3 -> (r2)
    mem[p] = enc(7, 3, 3, 3, 16'hFFFF);     p++;            // unknown op
    mem[p] = enc(3, 0, 0, 3, 0);            p++;            // st r3 -> (r0)
    mem[p] = enc(0, 3, 1, 2, 4);            p++;            // op 0 no-op
    mem[p] = enc(1, 4, 3, 3, 0);            p++;            // add doubling
    mem[p] = enc(3, 0, 1, 4, 0);            p++;
    mem[p] = enc(4, 0, 0, 0, 0);            p++;            // branch +0
    pdet = p;
    mem[p] = enc(4, 0, 0, 0, 32'h1F0 - (pdet * 4 + 4)); p++;
    mem[32'h1F0 >> 2] = enc(4, 0, 0, 0, (pdet * 4 + 4) - (32'h1F0 + 4));
    mem[p] = enc(4, 0, 0, 0, 8);            p++;            // skip two words
    p += 2;

    for (int n = 0; n < 80 && p < 8'h70; n++) begin
      r = int'($urandom % 20);
      if (r < 7)       mem[p] = enc(1, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 0);
      else if (r < 12) mem[p] = enc(2, int'($urandom % 8), int'($urandom % 8), 0, 0);
      else if (r < 17) mem[p] = enc(3, 0, int'($urandom % 8), int'($urandom % 8), 0);
      else if (r < 19) begin
        k = int'($urandom % 3);
        mem[p] = enc(4, 0, 0, 0, 4 * k);
        p += k;
      end else begin
        k = int'($urandom % 12);
        mem[p] = enc((k == 0) ? 0 : 4 + k, 5, 6, 7, 0);
      end
      p++;
    end
    mem[p] = enc(4, 0, 0, 0, -4);   // self loop ends the model

    // reference interpreter builds the expected access list
    for (int i = 0; i < 8; i++) rg[i] = '0;
    pc = '0; gap = 0; tag = "R1"; halted = 0;
    for (int n = 0; n < 400 && !halted; n++) begin
      w = mem[pc[9:2]];
      push(1'b0, pc, '0, gap, tag);
      off = {{16{w[15]}}, w[15:0]};
      pc = pc + 4; tag = "R2";
      case (w[31:28])
        4'h1: begin rg[w[26:24]] = rg[w[22:20]] + rg[w[18:16]]; gap = 6; end
        4'h2: begin
          push(1'b0, rg[w[22:20]], '0, 3, "R4");
          rg[w[26:24]] = mem[rg[w[22:20]][9:2]];
          gap = 3;
        end
        4'h3: begin push(1'b1, rg[w[22:20]], rg[w[18:16]], 4, "R5"); gap = 2; end
        4'h4: begin
          if (w[15:0] == 16'hFFFC) halted = 1;
          pc = pc + off; gap = 5; tag = "R6";
        end
        default: begin gap = 4; tag = "R10"; end
      endcase
    end

    // reset phase
    repeat (4) @(negedge clk);
    chk(mem_req == 1'b0, "R1", "request low in reset", W'(mem_req), W'(0));
    rst = 1'b0;
    #1;
    chk(mem_req == 1'b0, "R1", "request low after release", W'(mem_req), W'(0));
    chk(mem_addr == '0, "R1", "address register cleared", mem_addr, '0);

    while (n_seen < n_exp && cyc < 150000) @(negedge clk);
    if (n_seen < n_exp) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog accesses actual=%0d expected=%0d", n_seen, n_exp);
    end
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule